// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Level Thresholds

This block is a 9-bit first-in first-out buffer with independent write and read clocks. It has a full flag and an empty flag, and it has two threshold flags: one for "nearly full" and one for "nearly empty". The depth is a power-of-two parameter, from 64 to 8192 words. Each pointer crosses into the other clock domain as Gray code through a two-flop synchroniser. Each domain then derives its own word count and its own flags from its local pointer and the synchronised remote pointer.

The write-side pin `wen2_ld_i` has two possible roles. The write clock samples its level while reset is held, and that level fixes the role until the next reset:

- **High (dual-enable mode):** the pin is a second, active-high write enable.
- **Low (load mode):** the pin steers write cycles away from the storage. A write cycle with the pin low latches the data bus into one of two threshold registers. The loads alternate between the registers, nearly-empty first and nearly-full second.

A typical use is to reset the block in load mode, program both thresholds over the data bus, and then stream data.

Top module: `prog_flag_fifo`

## Requirements
- R1: While reset is held and right after it is released: `ef_o`=1, `ff_o`=0, `paf_o`=0, `pae_o`=1, `dout_o`=0. Both thresholds are 7.
- R2: A word is stored on a rising edge of `wclk_i` when `wen_ni`=0, `wen2_ld_i`=1 and the buffer is not full. Words are read back in the order they were written.
- R3: While `ff_o`=1, write cycles are ignored and the stored words stay unchanged.
- R4: In dual-enable mode (`wen2_ld_i`=1 during reset), a write cycle with `wen2_ld_i`=0 stores nothing and changes no threshold.
- R5: In load mode (`wen2_ld_i`=0 during reset), a write cycle with `wen_ni`=0 and `wen2_ld_i`=0 loads `din_i` into a threshold register. It does not store the word in the buffer.
- R6: Threshold loads alternate: nearly-empty, then nearly-full, then nearly-empty again. Reset restarts the sequence at nearly-empty.
- R7: A word is read out to `dout_o` on a rising edge of `rclk_i` only when `ren1_ni`=0 and `ren2_ni`=0. With only one of them low, nothing is read.
- R8: A read while `ef_o`=1 is ignored and `dout_o` holds its value.
- R9: `pae_o`=1 exactly when the word count is at or below the nearly-empty threshold.
- R10: `paf_o`=1 exactly when the word count is at or above DEPTH minus the nearly-full threshold.
- R11: `ff_o` rises on the same write edge that stores word number DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 9 | Write data or threshold value |
| wen_ni | input | 1 | Write enable, active low |
| wen2_ld_i | input | 1 | Second write enable or threshold-load strobe (active low), role fixed at reset |
| ren1_ni | input | 1 | Read enable 1, active low |
| ren2_ni | input | 1 | Read enable 2, active low |
| dout_o | output | 9 | Registered read data |
| ff_o | output | 1 | Full |
| ef_o | output | 1 | Empty |
| paf_o | output | 1 | Nearly full |
| pae_o | output | 1 | Nearly empty |

## Verification
The write-side flags `ff_o` and `paf_o` change on the write edge that moves the write pointer. They are sampled at the next falling write edge. Read data is registered on the accepting read edge, so the scoreboard monitor compares `dout_o` at the falling read edge that follows. A change made in one domain reaches the other domain's flags only after a Gray register and two synchroniser flops, which is two to three edges of the receiving clock. The bench therefore waits eight edges of each clock before it samples `ef_o`, `pae_o`, or any flag that depends on the opposite domain.

// File: rtl/pff_pkg.sv
package pff_pkg;
  localparam int DATA_W      = 9;
  localparam int OFF_W       = 9;
  localparam int OFF_DEFAULT = 7;

  typedef enum logic {MODE_LOAD = 1'b0, MODE_DUAL = 1'b1} fifo_mode_e;
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} off_sel_e;
endpackage

// File: rtl/pff_gray_sync.sv
module pff_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/pff_ram.sv
module pff_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pff_wr_ctl.sv
module pff_wr_ctl
  import pff_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              wen_ni,
  input  logic              wen2_ld_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [PW-1:0]     rgray_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [PW-1:0]     wgray_o,
  output logic [PW-1:0]     wbin_o,
  output logic              ff_o,
  output logic              paf_o,
  output logic [OFF_W-1:0]  ae_off_o,
  output logic              mode_dual_o
);
  localparam int SW = ((PW > OFF_W) ? PW : OFF_W) + 1;

  fifo_mode_e        mode_q;
  off_sel_e          sel_q;
  logic [PW-1:0]     wbin_q, wbin_d, wgray_q, rbin_s, wcnt;
  logic [OFF_W-1:0]  ae_q, af_q;
  logic              load;

  pff_gray_sync #(.W(PW)) u_rsync (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .gray_i(rgray_i),
    .bin_o (rbin_s)
  );

  // pin role is latched on every write edge while reset is held
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) mode_q <= wen2_ld_i ? MODE_DUAL : MODE_LOAD;
  end

  assign wcnt   = wbin_q - rbin_s;
  assign ff_o   = (wcnt == PW'(DEPTH));
  assign we_o   = !wen_ni && wen2_ld_i && !ff_o;
  assign load   = (mode_q == MODE_LOAD) && !wen_ni && !wen2_ld_i;
  assign wbin_d = wbin_q + PW'(we_o);
  assign paf_o  = (SW'(wcnt) + SW'(af_q)) >= SW'(DEPTH);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ae_q    <= OFF_W'(OFF_DEFAULT);
      af_q    <= OFF_W'(OFF_DEFAULT);
      sel_q   <= SEL_AE;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
      if (load) begin
        if (sel_q == SEL_AE) ae_q <= din_i;
        else                 af_q <= din_i;
        sel_q <= (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
      end
    end
  end

  assign waddr_o     = wbin_q[AW-1:0];
  assign wgray_o     = wgray_q;
  assign wbin_o      = wbin_q;
  assign ae_off_o    = ae_q;
  assign mode_dual_o = (mode_q == MODE_DUAL);
endmodule

// File: rtl/pff_rd_ctl.sv
module pff_rd_ctl
  import pff_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             ren1_ni,
  input  logic             ren2_ni,
  input  logic [PW-1:0]    wgray_i,
  input  logic [OFF_W-1:0] ae_off_i,
  output logic             re_o,
  output logic [AW-1:0]    raddr_o,
  output logic [PW-1:0]    rgray_o,
  output logic [PW-1:0]    rbin_o,
  output logic             ef_o,
  output logic             pae_o
);
  localparam int SW = ((PW > OFF_W) ? PW : OFF_W) + 1;

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, wbin_s, rcnt;

  pff_gray_sync #(.W(PW)) u_wsync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .gray_i(wgray_i),
    .bin_o (wbin_s)
  );

  assign rcnt   = wbin_s - rbin_q;
  assign ef_o   = (rcnt == '0);
  assign re_o   = !ren1_ni && !ren2_ni && !ef_o;
  assign rbin_d = rbin_q + PW'(re_o);
  // threshold register lives in the write domain; treated as quasi-static
  assign pae_o  = SW'(rcnt) <= SW'(ae_off_i);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign rbin_o  = rbin_q;
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import pff_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic              wen_ni,
  input  logic              wen2_ld_i,
  input  logic              ren1_ni,
  input  logic              ren2_ni,
  output logic [DATA_W-1:0] dout_o,
  output logic              ff_o,
  output logic              ef_o,
  output logic              paf_o,
  output logic              pae_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic             we, re, mode_dual;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wgray, rgray, wbin, rbin;
  logic [OFF_W-1:0] ae_off;

  pff_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .wclk_i     (wclk_i),
    .rst_ni     (rst_ni),
    .wen_ni     (wen_ni),
    .wen2_ld_i  (wen2_ld_i),
    .din_i      (din_i),
    .rgray_i    (rgray),
    .we_o       (we),
    .waddr_o    (waddr),
    .wgray_o    (wgray),
    .wbin_o     (wbin),
    .ff_o       (ff_o),
    .paf_o      (paf_o),
    .ae_off_o   (ae_off),
    .mode_dual_o(mode_dual)
  );

  pff_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .rclk_i  (rclk_i),
    .rst_ni  (rst_ni),
    .ren1_ni (ren1_ni),
    .ren2_ni (ren2_ni),
    .wgray_i (wgray),
    .ae_off_i(ae_off),
    .re_o    (re),
    .raddr_o (raddr),
    .rgray_o (rgray),
    .rbin_o  (rbin),
    .ef_o    (ef_o),
    .pae_o   (pae_o)
  );

  pff_ram #(.DEPTH(DEPTH), .W(DATA_W)) u_ram (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(din_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (re),
    .raddr_i(raddr),
    .rdata_o(dout_o)
  );
endmodule

// File: rtl/prog_flag_fifo_chk.sv
module prog_flag_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wen_ni,
  input logic          wen2_ld_i,
  input logic          ren1_ni,
  input logic          ren2_ni,
  input logic [8:0]    dout_i,
  input logic          ff_i,
  input logic          ef_i,
  input logic          paf_i,
  input logic          pae_i,
  input logic          mode_dual_i,
  input logic [PW-1:0] wbin_i,
  input logic [PW-1:0] rbin_i
);
  always @(posedge wclk_i) begin
    if (!rst_ni) assert_reset_wflags_R1: assert (!ff_i && !paf_i);
  end

  always @(posedge rclk_i) begin
    if (!rst_ni) assert_reset_rflags_R1: assert (ef_i && pae_i);
  end

  assert_full_blocks_write_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ff_i |=> $stable(wbin_i));

  assert_dual_pin_low_R4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (mode_dual_i && !wen2_ld_i) |=> $stable(wbin_i));

  assert_load_no_store_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!mode_dual_i && !wen_ni && !wen2_ld_i) |=> $stable(wbin_i));

  assert_single_enable_R7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ren1_ni || ren2_ni) |=> $stable(rbin_i) && $stable(dout_i));

  assert_no_underflow_R8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ef_i |=> $stable(rbin_i) && $stable(dout_i));

  assert_empty_nearly_empty_R9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ef_i |-> pae_i);

  assert_full_nearly_full_R10: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ff_i |-> paf_i);
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk_i     (wclk_i),
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .wen_ni     (wen_ni),
  .wen2_ld_i  (wen2_ld_i),
  .ren1_ni    (ren1_ni),
  .ren2_ni    (ren2_ni),
  .dout_i     (dout_o),
  .ff_i       (ff_o),
  .ef_i       (ef_o),
  .paf_i      (paf_o),
  .pae_i      (pae_o),
  .mode_dual_i(mode_dual),
  .wbin_i     (wbin),
  .rbin_i     (rbin)
);

// File: tb/prog_flag_fifo_bench.sv
module prog_flag_fifo_bench;
  localparam int DEPTH = 64;

  logic       wclk = 1'b0, rclk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] din = '0, dout;
  logic       wen_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
  logic       ff, ef, paf, pae;

  int         n_tests = 0, n_fail = 0;
  logic [8:0] exp_q[$];
  logic       rd_arm = 1'b0;

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  prog_flag_fifo #(.DEPTH(DEPTH)) u_prog_flag_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .din_i(din),
    .wen_ni(wen_n), .wen2_ld_i(wen2_ld), .ren1_ni(ren1_n), .ren2_ni(ren2_n),
    .dout_o(dout), .ff_o(ff), .ef_o(ef), .paf_o(paf), .pae_o(pae)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic do_reset(input logic pin);
    rst_ni = 1'b0; wen_n = 1'b1; wen2_ld = pin; ren1_n = 1'b1; ren2_n = 1'b1;
    exp_q.delete();
    repeat (4) @(posedge wclk);
    repeat (2) @(posedge rclk);
    @(negedge wclk);
    rst_ni = 1'b1; wen2_ld = 1'b1;
    settle();
  endtask

  // driver: one write-clock edge, expected word pushed when the model accepts it
  task automatic wr(input logic [8:0] d, input logic wn, input logic pin);
    @(negedge wclk);
    din = d; wen_n = wn; wen2_ld = pin;
    if (!wn && pin && exp_q.size() < DEPTH) exp_q.push_back(d);
    @(negedge wclk);
    wen_n = 1'b1; wen2_ld = 1'b1;
  endtask

  task automatic rd(input logic r1, input logic r2);
    @(negedge rclk);
    ren1_n = r1; ren2_n = r2;
    @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  // monitor: arm on an accepted read edge, compare at the following falling edge
  always @(posedge rclk) rd_arm <= rst_ni && !ren1_n && !ren2_n && (exp_q.size() > 0);

  always @(negedge rclk) begin
    if (rd_arm) begin
      logic [8:0] e;
      e = exp_q.pop_front();
      check(dout == e, "R2", "read order dout", int'(dout), int'(e));
    end
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] last;
    // ---------------- dual-enable mode ----------------
    rst_ni = 1'b0; wen2_ld = 1'b1;
    repeat (2) @(negedge wclk);
    check(ef == 1'b1, "R1", "ef in reset", ef, 1);
    check(ff == 1'b0 && paf == 1'b0, "R1", "ff|paf in reset", ff | paf, 0);
    do_reset(1'b1);
    check(ef && pae && !ff && !paf, "R1", "flags after reset", {ef, pae, ff, paf}, 4'b1100);
    check(dout == '0, "R1", "dout after reset", dout, 0);

    wr(9'h055, 1'b0, 1'b0);
    settle();
    check(ef == 1'b1, "R4", "ef after pin-low write", ef, 1);

    for (int i = 0; i < 7; i++) wr(9'((i * 37 + 11) & 9'h1ff), 1'b0, 1'b1);
    settle();
    check(ef == 1'b0, "R2", "ef after 7 writes", ef, 0);
    check(pae == 1'b1, "R9", "pae at count 7", pae, 1);
    wr(9'h123, 1'b0, 1'b1);
    settle();
    check(pae == 1'b0, "R9", "pae at count 8 (threshold still 7, R4)", pae, 0);

    for (int i = 8; i < 56; i++) wr(9'((i * 37 + 11) & 9'h1ff), 1'b0, 1'b1);
    settle();
    check(paf == 1'b0, "R10", "paf at count 56", paf, 0);
    wr(9'h0f0, 1'b0, 1'b1);
    @(negedge wclk);
    check(paf == 1'b1, "R10", "paf at count 57", paf, 1);

    for (int i = 57; i < 63; i++) wr(9'((i * 37 + 11) & 9'h1ff), 1'b0, 1'b1);
    check(ff == 1'b0, "R11", "ff at count 63", ff, 0);
    wr(9'h1c3, 1'b0, 1'b1);
    check(ff == 1'b1, "R11", "ff at count 64", ff, 1);
    wr(9'h1aa, 1'b0, 1'b1);
    check(ff == 1'b1, "R3", "ff after blocked write", ff, 1);

    rd(1'b0, 1'b1);
    rd(1'b1, 1'b0);
    settle();
    check(ff == 1'b1, "R7", "ff after single-enable reads", ff, 1);
    check(dout == '0, "R7", "dout after single-enable reads", dout, 0);

    for (int i = 0; i < DEPTH; i++) rd(1'b0, 1'b0);
    settle();
    check(exp_q.size() == 0, "R3", "scoreboard left", exp_q.size(), 0);
    check(ef == 1'b1, "R2", "ef after drain", ef, 1);
    last = dout;
    check(last == 9'h1c3, "R3", "last word survives full write", last, 9'h1c3);
    rd(1'b0, 1'b0);
    @(negedge rclk);
    check(dout == last, "R8", "dout after empty read", dout, last);

    // ---------------- load mode ----------------
    do_reset(1'b0);
    wr(9'd3, 1'b0, 1'b0);
    wr(9'd10, 1'b0, 1'b0);
    settle();
    check(ef == 1'b1, "R5", "ef after two loads", ef, 1);
    for (int i = 0; i < 3; i++) wr(9'(i + 100), 1'b0, 1'b1);
    settle();
    check(pae == 1'b1, "R6", "pae at count 3 (ae=3)", pae, 1);
    wr(9'd200, 1'b0, 1'b1);
    settle();
    check(pae == 1'b0, "R6", "pae at count 4 (ae=3)", pae, 0);
    for (int i = 4; i < 53; i++) wr(9'((i * 13) & 9'h1ff), 1'b0, 1'b1);
    settle();
    check(paf == 1'b0, "R6", "paf at count 53 (af=10)", paf, 0);
    wr(9'h077, 1'b0, 1'b1);
    settle();
    check(paf == 1'b1, "R6", "paf at count 54 (af=10)", paf, 1);
    wr(9'd60, 1'b0, 1'b0);
    settle();
    check(pae == 1'b1, "R6", "pae after third load (ae=60)", pae, 1);
    check(paf == 1'b1, "R5", "paf unchanged by load", paf, 1);
    for (int i = 0; i < 54; i++) rd(1'b0, 1'b0);
    settle();
    check(exp_q.size() == 0, "R5", "scoreboard left", exp_q.size(), 0);
    check(ef == 1'b1, "R5", "ef after drain", ef, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule